// File: doc/BRIEF.md
# Serial Signature Analysis Register

This block reduces a long single-bit response stream from a circuit under test to a short signature. It treats the incoming bits as the coefficients of a polynomial, highest order first, and divides that polynomial over GF(2) by a characteristic polynomial fixed at build time. Each accepted bit advances the division by one step. The bit that leaves the top stage is the next quotient coefficient, and the register contents that remain are the remainder.

A built-in counter accepts exactly the configured number of bits and then freezes the register. Once that point is reached, the remainder is compared with a fault-free signature supplied as a parameter, and a pass flag reports the outcome. Reset clears the register and the counter so that a new compression run can start.

Top module: `serial_sig_analyzer`

## Requirements
- R1: While reset is high at a clock edge, the register, the bit counter and the quotient-valid flag are cleared after that edge. As a result, `signature` is 0 and `done`, `pass` and `quo_valid` are 0.
- R2: The parameter `POLY` holds the coefficients of g(x). Bit i of `POLY` is the coefficient of x^i for i below `WIDTH`, and the x^`WIDTH` term is always present. On each accepted bit, stage 0 takes `din` and stage i takes stage i-1. Every stage whose `POLY` bit is 1 also has the old top stage XORed into it.
- R3: After `TEST_LEN` accepted bits, bit i of `signature` equals the coefficient of x^i in M(x) mod g(x). M(x) is built from the accepted bits, with the first accepted bit as the highest-order term.
- R4: `quo_bit` holds the old top stage that the last accepted bit pushed out. `quo_valid` is high for one cycle after each accepted bit from the (`WIDTH`+1)-th onward. The valid quotient bits give Q(x) with the highest order first.
- R5: A cycle with `en` low leaves `signature` unchanged and keeps `quo_valid` low.
- R6: `done` rises after the `TEST_LEN`-th accepted bit and stays high until reset. Bits offered while `done` is high leave `signature` unchanged.
- R7: `pass` is high exactly when `done` is high and `signature` equals `GOLDEN`.
- R8: With the defaults (g(x) = x^4+x^3+1, `TEST_LEN` 9, `GOLDEN` 4'hD), the input stream 1,1,0,1,1,0,1,1,0 gives the quotient bits 1,0,0,1,1. It leaves `signature` = 4'b1101 and sets `pass`.
- R9: When bit 0 of `POLY` is 1, flipping any burst of input bits shorter than `WIDTH` changes the final signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset that clears the register and the counter |
| en | input | 1 | Offer `din` for compression in this cycle |
| din | input | 1 | Serial response bit |
| quo_bit | output | 1 | Quotient bit from the last accepted shift |
| quo_valid | output | 1 | `quo_bit` is a valid quotient coefficient |
| signature | output | WIDTH | Current remainder |
| done | output | 1 | Test length reached, compression frozen |
| pass | output | 1 | Done and remainder equals the golden signature |

## Verification
On every cycle, the assertions check the following. The register holds when no bit is accepted. The quotient bit is the stage that was just shifted out. `done` never drops before reset and the counter never passes the test length. `pass` never appears without `done`. The remainder and quotient values themselves, for varied streams, two polynomials, pauses in `en`, extra bits after completion and burst errors, are shown only by the bench's scenarios. The bench compares them against a long-division model computed independently of the shift structure.

// File: rtl/sig_pkg.sv
package sig_pkg;
  // Bits needed to count from 0 up to len inclusive.
  function automatic int unsigned ctr_bits(int unsigned len);
    int unsigned b;
    b = $clog2(len + 1);
    return (b < 1) ? 1 : b;
  endfunction
endpackage

// File: rtl/sig_len_ctr.sv
module sig_len_ctr #(
  parameter int unsigned TEST_LEN = 9,
  parameter int unsigned QSTART   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic step,
  output logic past_n,
  output logic done
);
  localparam int unsigned CW = sig_pkg::ctr_bits(TEST_LEN);
  localparam logic [CW-1:0] LEN_C = CW'(TEST_LEN);

  logic [CW-1:0] cnt_q;

  assign done   = (cnt_q == LEN_C);
  assign step   = en && !done;
  assign past_n = (32'(cnt_q) >= QSTART);

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  // R6
  len_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q <= LEN_C));
endmodule

// File: rtl/sig_shift_core.sv
module sig_shift_core #(
  parameter int unsigned     WIDTH = 4,
  parameter logic [WIDTH-1:0] POLY = 4'h9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             past_n,
  input  logic             din,
  output logic [WIDTH-1:0] sig,
  output logic             quo_bit,
  output logic             quo_valid
);
  logic [WIDTH-1:0] sig_q;
  logic [WIDTH-1:0] sig_d;
  logic             fb;
  logic             quo_q;
  logic             qv_q;

  assign fb = sig_q[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic from_prev;
    if (i == 0) begin : g_head
      assign from_prev = din;
    end else begin : g_body
      assign from_prev = sig_q[i-1];
    end
    assign sig_d[i] = from_prev ^ (POLY[i] & fb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_q <= '0;
      quo_q <= 1'b0;
      qv_q  <= 1'b0;
    end else begin
      qv_q <= step && past_n;
      if (step) begin
        sig_q <= sig_d;
        quo_q <= fb;
      end
    end
  end

  assign sig       = sig_q;
  assign quo_bit   = quo_q;
  assign quo_valid = qv_q;

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(sig_q));

  // R4
  quo_src_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> (quo_bit == $past(sig_q[WIDTH-1])));
endmodule

// File: rtl/sig_golden_cmp.sv
module sig_golden_cmp #(
  parameter int unsigned      WIDTH  = 4,
  parameter logic [WIDTH-1:0] GOLDEN = 4'hD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic [WIDTH-1:0] sig,
  output logic             pass
);
  logic match;
  assign match = (sig == GOLDEN);
  assign pass  = done && match;

  // R7
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);
endmodule

// File: rtl/serial_sig_analyzer.sv
module serial_sig_analyzer #(
  parameter int unsigned      WIDTH    = 4,
  parameter logic [WIDTH-1:0] POLY     = 4'h9,
  parameter int unsigned      TEST_LEN = 9,
  parameter logic [WIDTH-1:0] GOLDEN   = 4'hD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             din,
  output logic             quo_bit,
  output logic             quo_valid,
  output logic [WIDTH-1:0] signature,
  output logic             done,
  output logic             pass
);
  logic step;
  logic past_n;

  sig_len_ctr #(.TEST_LEN(TEST_LEN), .QSTART(WIDTH)) u_ctr (
    .clk(clk), .rst(rst), .en(en),
    .step(step), .past_n(past_n), .done(done)
  );

  sig_shift_core #(.WIDTH(WIDTH), .POLY(POLY)) u_core (
    .clk(clk), .rst(rst), .step(step), .past_n(past_n), .din(din),
    .sig(signature), .quo_bit(quo_bit), .quo_valid(quo_valid)
  );

  sig_golden_cmp #(.WIDTH(WIDTH), .GOLDEN(GOLDEN)) u_cmp (
    .clk(clk), .rst(rst), .done(done), .sig(signature), .pass(pass)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (signature == '0 && !done && !quo_valid));
endmodule

// File: tb/serial_sig_analyzer_test.sv
`timescale 1ns/1ps
module serial_sig_analyzer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic din = 1'b0;
  always #5 clk = ~clk;

  logic       qb_a, qv_a, done_a, pass_a;
  logic [3:0] sig_a;
  logic       qb_b, qv_b, done_b, pass_b;
  logic [7:0] sig_b;

  serial_sig_analyzer uut (
    .clk(clk), .rst(rst), .en(en), .din(din),
    .quo_bit(qb_a), .quo_valid(qv_a), .signature(sig_a), .done(done_a), .pass(pass_a));

  serial_sig_analyzer #(.WIDTH(8), .POLY(8'h1D), .TEST_LEN(40), .GOLDEN(8'h00)) uut_w8 (
    .clk(clk), .rst(rst), .en(en), .din(din),
    .quo_bit(qb_b), .quo_valid(qv_b), .signature(sig_b), .done(done_b), .pass(pass_b));

  int checks = 0;
  int failures = 0;
  logic [63:0] qa, qbb;
  int na, nb;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Long division over GF(2), operand m of length len, divisor pf of degree w.
  function automatic void div_model(input logic [63:0] m, input int len, input int w,
                                    input logic [63:0] pf,
                                    output logic [63:0] r, output logic [63:0] q);
    logic [63:0] t;
    t = m; q = '0;
    for (int d = len - 1; d >= w; d--) begin
      q = q << 1;
      if (t[d]) begin
        t = t ^ (pf << (d - w));
        q[0] = 1'b1;
      end
    end
    r = t & ((64'd1 << w) - 1);
  endfunction

  task automatic grab();
    if (qv_a) begin qa = {qa[62:0], qb_a}; na++; end
    if (qv_b) begin qbb = {qbb[62:0], qb_b}; nb++; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; en = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  // Feed len bits of m, highest first; optionally pause en mid-stream.
  task automatic run_stream(input logic [63:0] m, input int len, input bit gap);
    logic [7:0] held;
    qa = '0; qbb = '0; na = 0; nb = 0;
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); grab();
      if (gap && i == len - 12) begin
        en = 1'b0; held = sig_b;
        for (int k = 0; k < 3; k++) begin
          @(negedge clk); grab();
          chk(!qv_b, "R5", "quo_valid during pause", {63'd0, qv_b}, 64'd0);
        end
        chk(sig_b == held, "R5", "signature held while en low", {56'd0, sig_b}, {56'd0, held});
      end
      din = m[i]; en = 1'b1;
    end
    @(negedge clk); grab(); en = 1'b0; din = 1'b0;
    @(negedge clk); grab();
  endtask

  task automatic check_run(input logic [63:0] m, input string tag);
    logic [63:0] ra, qxa, rb, qxb;
    div_model(m >> 31, 9, 4, 64'h19, ra, qxa);
    div_model(m, 40, 8, 64'h11D, rb, qxb);
    chk(sig_a == ra[3:0], "R3", {tag, " remainder w4"}, {60'd0, sig_a}, ra);
    chk(sig_b == rb[7:0], "R3", {tag, " remainder w8"}, {56'd0, sig_b}, rb);
    chk(na == 5 && qa == qxa, "R4", {tag, " quotient w4"}, qa, qxa);
    chk(nb == 32 && qbb == qxb, "R4", {tag, " quotient w8"}, qbb, qxb);
    chk(done_a && done_b, "R6", {tag, " done"}, {62'd0, done_a, done_b}, 64'd3);
    chk(pass_a == (ra[3:0] == 4'hD), "R7", {tag, " pass w4"}, {63'd0, pass_a}, {63'd0, ra[3:0] == 4'hD});
    chk(pass_b == (rb[7:0] == 8'h00), "R7", {tag, " pass w8"}, {63'd0, pass_b}, {63'd0, rb[7:0] == 8'h00});
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [63:0] m, r, q, e;
    logic [7:0] s_clean, s_a, s_b;
    void'($urandom(32'h5EED));
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sig_a == 0 && sig_b == 0, "R1", "signature after reset", {52'd0, sig_a, sig_b}, 64'd0);
    chk(!done_a && !pass_a && !qv_a && !done_b && !qv_b, "R1", "flags after reset",
        {59'd0, done_a, pass_a, qv_a, done_b, qv_b}, 64'd0);

    // R8 directed example: first nine bits 110110110
    m = {9'b110110110, 31'h2A5C_3F1};
    run_stream(m, 40, 1'b0);
    chk(sig_a == 4'b1101, "R8", "example remainder", {60'd0, sig_a}, 64'hD);
    chk(qa[4:0] == 5'b10011 && na == 5, "R8", "example quotient", qa, 64'h13);
    chk(pass_a, "R8", "example pass", {63'd0, pass_a}, 64'd1);
    check_run(m, "directed");

    // R6 bits after done are ignored
    s_a = {4'd0, sig_a}; s_b = sig_b;
    for (int k = 0; k < 5; k++) begin @(negedge clk); din = k[0]; en = 1'b1; end
    @(negedge clk); en = 1'b0;
    chk({4'd0, sig_a} == s_a && sig_b == s_b && done_a && done_b, "R6", "frozen after done",
        {52'd0, sig_a, sig_b}, {52'd0, s_a[3:0], s_b});

    // R1 reset after a run
    do_reset();
    chk(sig_b == 0 && !done_b && !pass_a, "R1", "reset after run", {56'd0, sig_b}, 64'd0);

    // All-ones and all-zeros streams
    run_stream(64'hFF_FFFF_FFFF, 40, 1'b0); check_run(64'hFF_FFFF_FFFF, "ones");
    do_reset();
    run_stream(64'd0, 40, 1'b0); check_run(64'd0, "zeros");
    chk(pass_b, "R7", "zero stream matches zero golden", {63'd0, pass_b}, 64'd1);

    // R2 R3 R4 R5 random streams, some with pauses
    for (int t = 0; t < 20; t++) begin
      do_reset();
      m = {24'd0, $urandom(), $urandom()} & 64'hFF_FFFF_FFFF;
      run_stream(m, 40, t[0]);
      check_run(m, "random R2");
    end

    // R9 burst errors shorter than the register width
    for (int t = 0; t < 8; t++) begin
      int len, pos;
      do_reset();
      m = {24'd0, $urandom(), $urandom()} & 64'hFF_FFFF_FFFF;
      run_stream(m, 40, 1'b0);
      s_clean = sig_b;
      len = 1 + ($urandom() % 7);
      pos = $urandom() % (41 - len);
      e = (len == 1) ? 64'd1 : ((64'd1 | (64'd1 << (len - 1)) |
          ({32'd0, $urandom()} & ((64'd1 << len) - 1))));
      e = e << pos;
      do_reset();
      run_stream(m ^ e, 40, 1'b0);
      div_model(m ^ e, 40, 8, 64'h11D, r, q);
      chk(sig_b != s_clean && sig_b == r[7:0], "R9", "burst changes signature",
          {56'd0, sig_b}, r);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule